// File: doc/BRIEF.md
# Per-Core Interrupt Priority Arbiter and Acknowledge Unit

This block is the core-facing half of an interrupt controller, one instance per processing element. A separate state tracker keeps the per-source pending and enable state, priorities and group assignments. This block takes those vectors and picks the single best candidate. It then applies the group enables, the priority mask and the preemption rule, and raises either a normal interrupt line or a fast interrupt line towards the core.

Software running on the core reads an acknowledge port, which returns either the source ID or a special code. Each real acknowledge pushes the source's priority onto a small stack of running priorities and sends an acknowledge strobe back to the tracker. A completion write drops the running priority back to the earlier level. A mode input decides whether that same write also deactivates the source, or whether a separate deactivate write is needed. Deactivations are reported to the tracker as a strobe carrying the source ID.

Top module: `irq_cpu_if`

## Requirements
- R1: The candidate is the pending, enabled source whose group is enabled and whose full 8-bit priority is numerically smallest. Priority 0x00 is the most urgent. Equal priorities go to the lowest source ID. The binary point plays no part in this choice.
- R2: A source can be signalled only if three conditions hold: its group enable is set (`grp_en` bit 0 = group 0, bit 1 = secure group 1, bit 2 = non-secure group 1), its own enable bit is set, and its priority is strictly below `pri_mask`. The group code is 0 = group 0, 1 = secure group 1, 2 = non-secure group 1. Code 3 is never eligible.
- R3: `run_prio` reads 0xFF when no acknowledged source is outstanding. An acknowledge sets it to the priority of the acknowledged source. Each priority drop restores the value it had before the matching acknowledge.
- R4: The candidate preempts only when it is more urgent than the running priority once the low `bin_point` bits of both values are cleared. With `bin_point`=4, 0x21 does not preempt 0x20, but 0x10 does. When nothing is outstanding, any candidate that passes R2 is allowed.
- R5: Group 0 is always routed to `fiq_o`, and so is everything when `pe_top_el`=1. Otherwise a group 1 source goes to `irq_o` if it matches `pe_secure` (1S with `pe_secure`=1, 1NS with `pe_secure`=0) and to `fiq_o` if it does not. The two lines are never high together.
- R6: `ack_id` gives the candidate's ID only when the candidate is signalled and belongs to the selected acknowledge group. For `ack_grp1`=1, that means group 1 of the current security state. Otherwise it gives 1023. There are two exceptions: a group 0 acknowledge with `pe_top_el`=1 returns 1020 for a secure group 1 candidate and 1021 for a non-secure one, and a read in the same cycle as `eoi_wr` returns 1023. A read that returns a special code raises no `ack_vld` and leaves `run_prio` unchanged.
- R7: With `eoi_split`=0, `eoi_wr` drops the priority and raises `deact_vld` with `deact_id`=`eoi_id` in the same cycle, and `dir_wr` has no effect. With `eoi_split`=1, `eoi_wr` only drops the priority, and `dir_wr` raises `deact_vld` with `dir_id`. A completion write when nothing is outstanding changes nothing and raises no strobe.
- R8: While the running-priority stack holds `STACK_DEPTH` entries, nothing is signalled and acknowledges return 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | NUM_IRQ | Pending bit per source |
| src_en | input | NUM_IRQ | Enable bit per source |
| src_prio | input | 8*NUM_IRQ | Priority per source, source i in bits [8i+7:8i] |
| src_grp | input | 2*NUM_IRQ | Group code per source, source i in bits [2i+1:2i] |
| grp_en | input | 3 | Group enables: G0, G1 secure, G1 non-secure |
| pri_mask | input | 8 | Priority mask |
| bin_point | input | 3 | Number of low sub-priority bits ignored for preemption |
| pe_secure | input | 1 | Core runs in the secure state |
| pe_top_el | input | 1 | Core runs at the highest exception level |
| eoi_split | input | 1 | 1 = priority drop and deactivate are separate writes |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_grp1 | input | 1 | Acknowledge group: 0 = group 0, 1 = group 1 |
| eoi_wr | input | 1 | Completion write strobe |
| eoi_id | input | 10 | ID carried by the completion write |
| dir_wr | input | 1 | Separate deactivate write strobe |
| dir_id | input | 10 | ID carried by the deactivate write |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| ack_id | output | 10 | Acknowledge read data |
| ack_vld | output | 1 | Acknowledge strobe to the tracker, ID on `ack_id` |
| deact_vld | output | 1 | Deactivate strobe to the tracker |
| deact_id | output | 10 | ID being deactivated |
| run_prio | output | 8 | Current running priority |

## Verification
The hardest state to reach is a full running-priority stack. Getting there takes four acknowledges in a row, and each one must be strictly more urgent than the one before, or R4 blocks it. The bench builds this state by lowering a single source's priority value between acknowledges. It then checks that a fifth, still more urgent source stays silent. After that it unwinds the stack one drop at a time and checks that each earlier level comes back in order. The binary-point corner is reached in two steps: the bench first leaves a coarse-grouped priority running, then offers a candidate that differs from it only in the sub-priority bits.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
   localparam int PRIO_W = 8;
   localparam int ID_W   = 10;
   localparam logic [ID_W-1:0] ID_NONE  = 10'd1023;
   localparam logic [ID_W-1:0] ID_OTH_S = 10'd1020;
   localparam logic [ID_W-1:0] ID_OTH_N = 10'd1021;
   localparam logic [PRIO_W-1:0] PRIO_IDLE = 8'hFF;

   typedef enum logic [1:0] {
      GRP_0   = 2'd0,
      GRP_1S  = 2'd1,
      GRP_1NS = 2'd2,
      GRP_OFF = 2'd3
   } grp_e;

   typedef struct packed {
      logic             found;
      logic [ID_W-1:0]  id;
      logic [PRIO_W-1:0] prio;
      grp_e             grp;
   } cand_t;
endpackage

// File: rtl/irq_best_sel.sv
module irq_best_sel
   import irq_cpu_pkg::*;
#(
   parameter int NUM_IRQ = 16,
   parameter int ID_BASE = 32
) (
   input  logic [NUM_IRQ-1:0]        src_pend,
   input  logic [NUM_IRQ-1:0]        src_en,
   input  logic [PRIO_W*NUM_IRQ-1:0] src_prio,
   input  logic [2*NUM_IRQ-1:0]      src_grp,
   input  logic [2:0]                grp_en,
   output cand_t                     best
);
   logic [NUM_IRQ-1:0] elig;

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
      grp_e gc;
      logic gok;
      assign gc = grp_e'(src_grp[2*g +: 2]);
      always_comb begin
         unique case (gc)
            GRP_0:   gok = grp_en[0];
            GRP_1S:  gok = grp_en[1];
            GRP_1NS: gok = grp_en[2];
            default: gok = 1'b0;
         endcase
      end
      assign elig[g] = src_pend[g] & src_en[g] & gok;
   end

   always_comb begin
      best = '{found: 1'b0, id: ID_NONE, prio: PRIO_IDLE, grp: GRP_OFF};
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (elig[i] && (!best.found || src_prio[PRIO_W*i +: PRIO_W] < best.prio)) begin
            best.found = 1'b1;
            best.id    = ID_W'(ID_BASE + i);
            best.prio  = src_prio[PRIO_W*i +: PRIO_W];
            best.grp   = grp_e'(src_grp[2*i +: 2]);
         end
      end
   end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack
   import irq_cpu_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PRIO_W-1:0] push_val,
   input  logic              pop,
   output logic [PRIO_W-1:0] top,
   output logic              empty,
   output logic              full
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (pop && !empty)      cnt <= cnt - 1'b1;
      else if (push && !full)      cnt <= cnt + 1'b1;
   end

   if (DEPTH == 1) begin : g_single
      logic [PRIO_W-1:0] slot;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             slot <= PRIO_IDLE;
         else if (push && !full) slot <= push_val;
      end
      assign top = empty ? PRIO_IDLE : slot;
   end else begin : g_array
      logic [PRIO_W-1:0] mem [DEPTH];
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[s] <= PRIO_IDLE;
            else if (push && !pop && !full && cnt == CNT_W'(s))
               mem[s] <= push_val;
         end
      end
      assign top = empty ? PRIO_IDLE : mem[cnt - 1'b1];
   end
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
   import irq_cpu_pkg::*;
#(
   parameter int NUM_IRQ     = 16,
   parameter int ID_BASE     = 32,
   parameter int STACK_DEPTH = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ-1:0]        src_pend,
   input  logic [NUM_IRQ-1:0]        src_en,
   input  logic [8*NUM_IRQ-1:0]      src_prio,
   input  logic [2*NUM_IRQ-1:0]      src_grp,
   input  logic [2:0]                grp_en,
   input  logic [7:0]                pri_mask,
   input  logic [2:0]                bin_point,
   input  logic                      pe_secure,
   input  logic                      pe_top_el,
   input  logic                      eoi_split,
   input  logic                      ack_rd,
   input  logic                      ack_grp1,
   input  logic                      eoi_wr,
   input  logic [9:0]                eoi_id,
   input  logic                      dir_wr,
   input  logic [9:0]                dir_id,
   output logic                      irq_o,
   output logic                      fiq_o,
   output logic [9:0]                ack_id,
   output logic                      ack_vld,
   output logic                      deact_vld,
   output logic [9:0]                deact_id,
   output logic [7:0]                run_prio
);
   localparam int LAST_ID = ID_BASE + NUM_IRQ - 1;

   if (NUM_IRQ < 1 || LAST_ID > 1019) begin : g_bad_range
      $error("irq_cpu_if: source IDs must lie in 0..1019");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("irq_cpu_if: STACK_DEPTH must be at least 1");
   end

   cand_t             best;
   logic [PRIO_W-1:0] stk_top;
   logic              stk_empty, stk_full;
   logic [PRIO_W-1:0] gmask;
   logic              preempt_ok, sig, to_fiq, cur_g1, drop;

   irq_best_sel #(.NUM_IRQ(NUM_IRQ), .ID_BASE(ID_BASE)) u_sel (
      .src_pend (src_pend),
      .src_en   (src_en),
      .src_prio (src_prio),
      .src_grp  (src_grp),
      .grp_en   (grp_en),
      .best     (best)
   );

   assign gmask      = PRIO_W'(8'hFF << bin_point);
   assign preempt_ok = stk_empty || ((best.prio & gmask) < (stk_top & gmask));
   assign sig        = best.found && (best.prio < pri_mask) && preempt_ok && !stk_full;

   assign cur_g1 = (best.grp == GRP_1S  &&  pe_secure) ||
                   (best.grp == GRP_1NS && !pe_secure);
   assign to_fiq = (best.grp == GRP_0) || pe_top_el || !cur_g1;

   assign irq_o = sig && !to_fiq;
   assign fiq_o = sig &&  to_fiq;

   always_comb begin
      ack_id = ID_NONE;
      if (sig && !eoi_wr) begin
         if (ack_grp1) begin
            if (cur_g1) ack_id = best.id;
         end else if (best.grp == GRP_0) begin
            ack_id = best.id;
         end else if (pe_top_el) begin
            ack_id = (best.grp == GRP_1S) ? ID_OTH_S : ID_OTH_N;
         end
      end
   end

   assign ack_vld  = ack_rd && (ack_id < ID_OTH_S);
   assign drop     = eoi_wr && !stk_empty;
   assign deact_vld = eoi_split ? dir_wr : drop;
   assign deact_id  = eoi_split ? dir_id : eoi_id;
   assign run_prio  = stk_top;

   irq_prio_stack #(.DEPTH(STACK_DEPTH)) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ack_vld),
      .push_val (best.prio),
      .pop      (drop),
      .top      (stk_top),
      .empty    (stk_empty),
      .full     (stk_full)
   );
endmodule

// File: rtl/irq_cpu_if_chk.sv
module irq_cpu_if_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       irq_o,
   input logic       fiq_o,
   input logic       ack_vld,
   input logic [9:0] ack_id,
   input logic [7:0] run_prio,
   input logic       eoi_wr,
   input logic       eoi_split,
   input logic       dir_wr,
   input logic       deact_vld,
   input logic       stk_empty,
   input logic       stk_full
);
   p_one_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_o, fiq_o}));

   p_ack_real_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> (ack_id < 10'd1020));

   p_ack_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |=> (run_prio < $past(run_prio)));

   p_drop_restores_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !stk_empty) |=> (run_prio > $past(run_prio)));

   p_split_no_deact_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_split && !dir_wr) |-> !deact_vld);

   p_full_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stk_full |-> !(irq_o || fiq_o));
endmodule

bind irq_cpu_if irq_cpu_if_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_o     (irq_o),
   .fiq_o     (fiq_o),
   .ack_vld   (ack_vld),
   .ack_id    (ack_id),
   .run_prio  (run_prio),
   .eoi_wr    (eoi_wr),
   .eoi_split (eoi_split),
   .dir_wr    (dir_wr),
   .deact_vld (deact_vld),
   .stk_empty (stk_empty),
   .stk_full  (stk_full)
);

// File: tb/irq_cpu_if_tb.sv
module irq_cpu_if_tb;
   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [N-1:0]   src_pend = '0, src_en = '1;
   logic [8*N-1:0] src_prio = '0;
   logic [2*N-1:0] src_grp = '0;
   logic [2:0]     grp_en = 3'b111;
   logic [7:0]     pri_mask = 8'hFF;
   logic [2:0]     bin_point = '0;
   logic pe_secure = 0, pe_top_el = 0, eoi_split = 0;
   logic ack_rd = 0, ack_grp1 = 0, eoi_wr = 0, dir_wr = 0;
   logic [9:0] eoi_id = '0, dir_id = '0;
   logic irq_o, fiq_o, ack_vld, deact_vld;
   logic [9:0] ack_id, deact_id;
   logic [7:0] run_prio;

   irq_cpu_if #(.NUM_IRQ(N), .ID_BASE(0), .STACK_DEPTH(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
      .src_prio(src_prio), .src_grp(src_grp), .grp_en(grp_en),
      .pri_mask(pri_mask), .bin_point(bin_point), .pe_secure(pe_secure),
      .pe_top_el(pe_top_el), .eoi_split(eoi_split), .ack_rd(ack_rd),
      .ack_grp1(ack_grp1), .eoi_wr(eoi_wr), .eoi_id(eoi_id), .dir_wr(dir_wr),
      .dir_id(dir_id), .irq_o(irq_o), .fiq_o(fiq_o), .ack_id(ack_id),
      .ack_vld(ack_vld), .deact_vld(deact_vld), .deact_id(deact_id),
      .run_prio(run_prio)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   typedef struct packed {
      logic [15:0] pend;
      logic [15:0] en;
      logic [2:0]  gen;
      logic [7:0]  pmask;
      logic        sel1;
      logic        top;
      logic        sec;
      logic        e_irq;
      logic        e_fiq;
      logic [9:0]  e_id;
   } vec_t;

   // Base set: i0 0x40 G0, i1 0x40 G1NS, i2 0x20 G1S, i3 0x20 G1NS,
   // i4 0xA0 G1NS, i5 0x10 code 3, others 0xF0 G1NS.
   localparam vec_t TBL [16] = '{
      '{16'h0001, 16'hFFFF, 3'b111, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd0},    // R1 R5
      '{16'h0003, 16'hFFFF, 3'b111, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd0},    // R1 tie
      '{16'h0002, 16'hFFFF, 3'b111, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'd1},    // R5
      '{16'h0002, 16'hFFFF, 3'b111, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'd1023}, // R6
      '{16'h000C, 16'hFFFF, 3'b111, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd1023}, // R1 R6
      '{16'h000C, 16'hFFFF, 3'b111, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd2},    // R5
      '{16'h0004, 16'hFFFF, 3'b111, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd1020}, // R6
      '{16'h0008, 16'hFFFF, 3'b111, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd1021}, // R6
      '{16'h0010, 16'hFFFF, 3'b111, 8'hA0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd1023}, // R2
      '{16'h0010, 16'hFFFF, 3'b111, 8'hA1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'd4},    // R2
      '{16'h0010, 16'hFFEF, 3'b111, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd1023}, // R2
      '{16'h0020, 16'hFFFF, 3'b111, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd1023}, // R2
      '{16'h0000, 16'hFFFF, 3'b111, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd1023}, // R6
      '{16'h0021, 16'hFFFF, 3'b111, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd0},    // R2
      '{16'h0003, 16'hFFFF, 3'b110, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'd1},    // R2
      '{16'h0004, 16'hFFFF, 3'b101, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd1023}  // R2
   };

   task automatic set_prio(input int i, input logic [7:0] p);
      src_prio[8*i +: 8] = p;
   endtask

   task automatic do_ack(input string req, input int exp_vld);
      @(negedge clk); ack_rd = 1; #1;
      chk({req, " ack_vld"}, int'(ack_vld), exp_vld);
      @(negedge clk); ack_rd = 0; #1;
   endtask

   task automatic do_eoi(input logic [9:0] id);
      @(negedge clk); eoi_wr = 1; eoi_id = id; #1;
   endtask

   task automatic end_eoi();
      @(negedge clk); eoi_wr = 0; #1;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         set_prio(i, 8'hF0);
         src_grp[2*i +: 2] = 2'd2;
      end
      set_prio(0, 8'h40); src_grp[1:0] = 2'd0;
      set_prio(1, 8'h40);
      set_prio(2, 8'h20); src_grp[5:4] = 2'd1;
      set_prio(3, 8'h20);
      set_prio(4, 8'hA0);
      set_prio(5, 8'h10); src_grp[11:10] = 2'd3;

      repeat (3) @(negedge clk);
      rst_n = 1; #1;
      chk("R3 reset run_prio", int'(run_prio), 8'hFF);
      chk("R2 reset irq", int'(irq_o), 0);
      chk("R2 reset fiq", int'(fiq_o), 0);

      foreach (TBL[k]) begin
         @(negedge clk);
         src_pend = TBL[k].pend; src_en = TBL[k].en; grp_en = TBL[k].gen;
         pri_mask = TBL[k].pmask; ack_grp1 = TBL[k].sel1;
         pe_top_el = TBL[k].top; pe_secure = TBL[k].sec;
         #1;
         chk($sformatf("R5 vec%0d irq", k), int'(irq_o), int'(TBL[k].e_irq));
         chk($sformatf("R5 vec%0d fiq", k), int'(fiq_o), int'(TBL[k].e_fiq));
         chk($sformatf("R6 vec%0d ack_id", k), int'(ack_id), int'(TBL[k].e_id));
      end

      // Directed: all non-secure group 1, group 1 acknowledge.
      @(negedge clk);
      for (int i = 0; i < N; i++) src_grp[2*i +: 2] = 2'd2;
      src_en = '1; grp_en = 3'b111; pri_mask = 8'hFF; pe_secure = 0;
      pe_top_el = 0; ack_grp1 = 1; bin_point = 3'd4;
      set_prio(0, 8'h21); set_prio(1, 8'h20); set_prio(2, 8'hF0);
      src_pend = 16'h0003; #1;
      chk("R1 binary point ignored in selection", int'(ack_id), 1);

      src_pend = 16'h0002;
      do_ack("R3 first ack", 1);
      chk("R3 run_prio after ack", int'(run_prio), 8'h20);

      src_pend = 16'h0001; #1;
      chk("R4 sub-priority does not preempt irq", int'(irq_o), 0);
      chk("R4 sub-priority ack_id", int'(ack_id), 1023);
      do_ack("R6 special code no ack", 0);
      chk("R6 run_prio unchanged", int'(run_prio), 8'h20);

      set_prio(2, 8'h10); src_pend = 16'h0005; #1;
      chk("R4 group preempt irq", int'(irq_o), 1);
      chk("R4 group preempt ack_id", int'(ack_id), 2);
      do_ack("R4 nested ack", 1);
      chk("R3 nested run_prio", int'(run_prio), 8'h10);
      src_pend = 16'h0000;

      eoi_split = 0;
      do_eoi(10'd2);
      chk("R7 mode0 deact_vld", int'(deact_vld), 1);
      chk("R7 mode0 deact_id", int'(deact_id), 2);
      end_eoi();
      chk("R3 drop restores", int'(run_prio), 8'h20);

      eoi_split = 1;
      do_eoi(10'd1);
      chk("R7 split eoi no deact", int'(deact_vld), 0);
      end_eoi();
      chk("R3 drop to idle", int'(run_prio), 8'hFF);
      @(negedge clk); dir_wr = 1; dir_id = 10'd1; #1;
      chk("R7 split dir deact_vld", int'(deact_vld), 1);
      chk("R7 split dir deact_id", int'(deact_id), 1);
      @(negedge clk); dir_wr = 0;

      eoi_split = 0;
      do_eoi(10'd7);
      chk("R7 empty eoi no deact", int'(deact_vld), 0);
      end_eoi();
      chk("R7 empty eoi run_prio", int'(run_prio), 8'hFF);
      @(negedge clk); dir_wr = 1; dir_id = 10'd3; #1;
      chk("R7 mode0 dir ignored", int'(deact_vld), 0);
      @(negedge clk); dir_wr = 0;

      bin_point = 3'd7; set_prio(3, 8'hF0); src_pend = 16'h0008; #1;
      chk("R4 idle allows any", int'(irq_o), 1);

      // Fill the stack.
      @(negedge clk); bin_point = 3'd0; src_pend = 16'h0001;
      set_prio(0, 8'h80); do_ack("R8 fill 1", 1);
      set_prio(0, 8'h60); do_ack("R8 fill 2", 1);
      set_prio(0, 8'h40); do_ack("R8 fill 3", 1);
      set_prio(0, 8'h20); do_ack("R8 fill 4", 1);
      set_prio(0, 8'h10); #1;
      chk("R8 full irq", int'(irq_o), 0);
      chk("R8 full ack_id", int'(ack_id), 1023);
      src_pend = '0;
      do_eoi(10'd0); end_eoi(); chk("R3 unwind 1", int'(run_prio), 8'h40);
      do_eoi(10'd0); end_eoi(); chk("R3 unwind 2", int'(run_prio), 8'h60);
      do_eoi(10'd0); end_eoi(); chk("R3 unwind 3", int'(run_prio), 8'h80);
      do_eoi(10'd0); end_eoi(); chk("R3 unwind 4", int'(run_prio), 8'hFF);

      summary();
   end
endmodule